// File: doc/BRIEF.md
# Byte-Lane Write Decode and Data Bus Direction Control

This block sits beside the address sequencer of a synchronous burst memory. Each clock it turns the active-low write controls (a global write, a byte-write enable and one select per byte lane) into per-lane capture enables for the write-data register. A registered write strobe per lane then completes the write one cycle later with no outside timing. The same block decides when the shared bidirectional data bus may be driven by the memory.

The sequencer reports what kind of cycle is under way, as one of five kinds: a new access from the processor strobe, a new access from the controller strobe, a burst advance, a deselect, or none of these (burst suspended). A processor-strobe access is always a read. A controller-strobe access, an advance or a suspend becomes a write when the write controls ask for one. A detected write turns the bus driver off at once, whatever the output enable says. The output enable is ignored for the first read clock after a deselect, and after a write the bus stays released until a new access or an advance is seen.

Top module: `lane_write_ctrl`

## Requirements
- R1: When the global write input is low in a write-eligible cycle, both lanes are captured, whatever the byte-write enable and the lane selects are.
- R2: With the global write high, lane i (bit 0 is lane A, bit 1 is lane B of `bwN`, `dinEn`, `wrStrobe`) is captured only when the byte-write enable is low and select i is low. Lane A data is `dqIn[8:0]` and lane B data is `dqIn[17:9]`.
- R3: With the global write high, a cycle whose byte-write enable is high, or whose lane selects are both high, captures no lane.
- R4: A processor-strobe cycle captures no lane, whatever the write inputs are, and counts as a read.
- R5: A controller-strobe cycle captures in that same cycle. The captured lanes show on `wrStrobe` for the following cycle, with their data on `wrData`.
- R6: In any cycle in which a capture is decoded, `driveEn` is low, even with the output enable low.
- R7: The first clock of a read that starts from the deselected state (including the state after reset) does not drive, whatever the output enable is. Later clocks of that read drive normally.
- R8: After a write, suspend cycles without a write keep the bus released. The next processor-strobe, controller-strobe or advance read drives again.
- R9: In a read, `driveEn` is high only when the output enable is low and the block is selected. It is low after a deselect cycle and during reset.
- R10: `wrStrobe` is high for exactly the one cycle after each capture. It is low after a cycle with no capture.
- R11: Advance and suspend cycles seen while deselected capture nothing and do not start a read.
- R12: When several cycle indicators are high together, deselect wins over the processor strobe, which wins over the controller strobe, which wins over advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | LANES | Lane selects, active low |
| oeN | input | 1 | Output enable, asynchronous, active low |
| cycProc | input | 1 | Cycle is a new access from the processor strobe |
| cycCtrl | input | 1 | Cycle is a new access from the controller strobe |
| cycCont | input | 1 | Cycle advances the burst |
| cycDesel | input | 1 | Cycle deselects the memory |
| dqIn | input | LANES*LANE_W | Data sampled from the bus |
| wrStrobe | output | LANES | Registered per-lane write strobe |
| wrData | output | LANES*LANE_W | Captured write data |
| dinEn | output | LANES | Per-lane enable of the write-data register |
| driveEn | output | 1 | Enable of the bus output driver |

## Verification
The hardest situation to reach is the interaction of history with the current cycle. The masked first read depends on having been deselected before. The held-off bus depends on an earlier write, and a write in a suspend cycle counts only after a selection. Directed sequences therefore chain deselect, read start, advance, suspend and write in the orders that set each of these up. A long random stretch follows, weighted towards suspend and advance cycles with random write controls and output enable, so that the stored state is exercised across many of its combinations, and the reference model is compared every clock.

// File: rtl/lane_write_pkg.sv
package lane_write_pkg;
  parameter int unsigned LANES = 2;

  typedef enum logic [2:0] {
    CK_HOLD,
    CK_CONT,
    CK_CTRL,
    CK_PROC,
    CK_DESEL
  } cyc_kind_e;

  typedef struct packed {
    logic [LANES-1:0] capture;
    logic             readValid;
    logic             wrNow;
  } lane_strobe_t;
endpackage

// File: rtl/lane_write_decode.sv
module lane_write_decode
  import lane_write_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  input  logic             cycProc,
  input  logic             cycCtrl,
  input  logic             cycCont,
  input  logic             cycDesel,
  output lane_strobe_t     strobes
);
  cyc_kind_e        kind;
  logic [LANES-1:0] laneReq;
  logic [LANES-1:0] capture;
  logic             eligible;
  logic             wrDet;
  logic             selQ;
  logic             readQ;
  logic             maskQ;

  always_comb begin
    if (cycDesel)     kind = CK_DESEL;
    else if (cycProc) kind = CK_PROC;
    else if (cycCtrl) kind = CK_CTRL;
    else if (cycCont) kind = CK_CONT;
    else              kind = CK_HOLD;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneReq[g] = ~gwN | (~bweN & ~bwN[g]);
  end

  assign eligible = (kind == CK_CTRL) |
                    (((kind == CK_CONT) | (kind == CK_HOLD)) & selQ);
  assign capture  = eligible ? laneReq : '0;
  assign wrDet    = |capture;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= 1'b0;
      readQ <= 1'b0;
      maskQ <= 1'b0;
    end else begin
      unique case (kind)
        CK_DESEL: begin
          selQ  <= 1'b0;
          readQ <= 1'b0;
          maskQ <= 1'b0;
        end
        CK_PROC: begin
          selQ  <= 1'b1;
          readQ <= 1'b1;
          maskQ <= ~selQ;
        end
        CK_CTRL: begin
          selQ  <= 1'b1;
          readQ <= ~wrDet;
          maskQ <= ~wrDet & ~selQ;
        end
        CK_CONT: begin
          readQ <= selQ & ~wrDet;
          maskQ <= 1'b0;
        end
        default: begin
          if (wrDet) readQ <= 1'b0;
          maskQ <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    strobes.capture   = capture;
    strobes.readValid = readQ & ~maskQ;
    strobes.wrNow     = wrDet;
  end
endmodule

// File: rtl/lane_write_datapath.sv
module lane_write_datapath
  import lane_write_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  lane_strobe_t      strobes,
  input  logic              oeN,
  input  logic [DATA_W-1:0] dqIn,
  output logic [LANES-1:0]  wrStrobe,
  output logic [DATA_W-1:0] wrData,
  output logic [LANES-1:0]  dinEn,
  output logic              driveEn
);
  assign dinEn   = strobes.capture;
  assign driveEn = strobes.readValid & ~strobes.wrNow & ~oeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrStrobe <= '0;
    else       wrStrobe <= strobes.capture;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_data
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        wrData[g*LANE_W +: LANE_W] <= '0;
      else if (strobes.capture[g])
        wrData[g*LANE_W +: LANE_W] <= dqIn[g*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/lane_write_ctrl.sv
module lane_write_ctrl
  import lane_write_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              oeN,
  input  logic              cycProc,
  input  logic              cycCtrl,
  input  logic              cycCont,
  input  logic              cycDesel,
  input  logic [DATA_W-1:0] dqIn,
  output logic [LANES-1:0]  wrStrobe,
  output logic [DATA_W-1:0] wrData,
  output logic [LANES-1:0]  dinEn,
  output logic              driveEn
);
  lane_strobe_t strobes;

  lane_write_decode u_decode (
    .clk(clk), .rstN(rstN), .gwN(gwN), .bweN(bweN), .bwN(bwN),
    .cycProc(cycProc), .cycCtrl(cycCtrl), .cycCont(cycCont),
    .cycDesel(cycDesel), .strobes(strobes)
  );

  lane_write_datapath #(.LANE_W(LANE_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .oeN(oeN), .dqIn(dqIn),
    .wrStrobe(wrStrobe), .wrData(wrData), .dinEn(dinEn), .driveEn(driveEn)
  );
endmodule

// File: rtl/lane_write_ctrl_chk.sv
module lane_write_ctrl_chk
  import lane_write_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             gwN,
  input logic             bweN,
  input logic [LANES-1:0] bwN,
  input logic             cycProc,
  input logic             cycDesel,
  input logic [LANES-1:0] dinEn,
  input logic [LANES-1:0] wrStrobe,
  input logic             driveEn
);
  // R6: a decoded capture keeps the bus released
  a_r6_write_releases_bus: assert property (@(posedge clk) disable iff (!rstN)
    (dinEn != '0) |-> !driveEn);

  // R4: processor-strobe cycles never capture
  a_r4_proc_no_capture: assert property (@(posedge clk) disable iff (!rstN)
    cycProc |-> (dinEn == '0));

  // R3: read encodings never capture
  a_r3_read_no_capture: assert property (@(posedge clk) disable iff (!rstN)
    (gwN && (bweN || (&bwN))) |-> (dinEn == '0));

  // R5 / R10: strobe is the capture of the previous cycle
  a_r5_strobe_follows_capture: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (wrStrobe == $past(dinEn)));

  // R9: no drive in the cycle after a deselect
  a_r9_desel_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    cycDesel |=> !driveEn);
endmodule

bind lane_write_ctrl lane_write_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .gwN(gwN), .bweN(bweN), .bwN(bwN),
  .cycProc(cycProc), .cycDesel(cycDesel), .dinEn(dinEn),
  .wrStrobe(wrStrobe), .driveEn(driveEn)
);

// File: tb/lane_write_ctrl_bench.sv
`timescale 1ns/1ps
module lane_write_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        gwN = 1'b1, bweN = 1'b1, oeN = 1'b1;
  logic [1:0]  bwN = 2'b11;
  logic        cycProc = 1'b0, cycCtrl = 1'b0, cycCont = 1'b0, cycDesel = 1'b0;
  logic [17:0] dqIn = '0;
  logic [1:0]  wrStrobe, dinEn;
  logic [17:0] wrData;
  logic        driveEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  bit        mSel = 0, mRead = 0, mMask = 0;
  bit [1:0]  mStrobe = 0;
  bit [17:0] mData = 0;

  always #5 clk = ~clk;

  lane_write_ctrl u_lane_write_ctrl (
    .clk(clk), .rstN(rstN), .gwN(gwN), .bweN(bweN), .bwN(bwN), .oeN(oeN),
    .cycProc(cycProc), .cycCtrl(cycCtrl), .cycCont(cycCont),
    .cycDesel(cycDesel), .dqIn(dqIn), .wrStrobe(wrStrobe), .wrData(wrData),
    .dinEn(dinEn), .driveEn(driveEn)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare before posedge, advance model at posedge
  task automatic step(input string tag, input bit d, input bit p, input bit c,
                      input bit a, input bit gw, input bit bwe, input bit [1:0] bw,
                      input bit oe, input bit [17:0] dq);
    int kind;
    bit [1:0] req, cap;
    bit elig, wr, expDrive;
    @(negedge clk);
    cycDesel = d; cycProc = p; cycCtrl = c; cycCont = a;
    gwN = gw; bweN = bwe; bwN = bw; oeN = oe; dqIn = dq;
    // priority: 4 deselect, 3 processor, 2 controller, 1 advance, 0 suspend
    kind = d ? 4 : p ? 3 : c ? 2 : a ? 1 : 0;
    for (int i = 0; i < 2; i++) req[i] = !gw || (!bwe && !bw[i]);
    elig = (kind == 2) || ((kind <= 1) && mSel);
    cap = elig ? req : 2'b00;
    wr = (cap != 0);
    expDrive = mRead && !mMask && !wr && !oe;
    #3;
    check(tag, "dinEn", dinEn, cap);
    check(tag, "driveEn", driveEn, expDrive);
    check(tag, "wrStrobe", wrStrobe, mStrobe);
    check(tag, "wrData", wrData, mData);
    @(posedge clk);
    mStrobe = cap;
    if (cap[0]) mData[8:0] = dq[8:0];
    if (cap[1]) mData[17:9] = dq[17:9];
    case (kind)
      4: begin mSel = 0; mRead = 0; mMask = 0; end
      3: begin mRead = 1; mMask = !mSel; mSel = 1; end
      2: begin
        if (wr) begin mRead = 0; mMask = 0; end
        else begin mRead = 1; mMask = !mSel; end
        mSel = 1;
      end
      1: begin if (mSel) mRead = !wr; mMask = 0; end
      default: begin if (wr) mRead = 0; mMask = 0; end
    endcase
  endtask

  initial begin
    #(10 * 50000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // reset with a write-looking controller cycle and output enable low
    cycCtrl = 1'b1; gwN = 1'b0; oeN = 1'b0; dqIn = 18'h3ffff;
    repeat (3) @(posedge clk);
    #2;
    check("R9", "reset driveEn", driveEn, 0);
    check("R10", "reset wrStrobe", wrStrobe, 0);
    check("R5", "reset wrData", wrData, 0);
    @(negedge clk);
    rstN = 1'b1;
    cycCtrl = 1'b0; gwN = 1'b1; oeN = 1'b1;

    // R11: advance/suspend while deselected after reset
    step("R11", 0,0,0,1, 0,1,2'b11, 0, 18'h00111);
    step("R11", 0,0,0,0, 1,0,2'b00, 0, 18'h00222);
    // R7: first read after deselected state masked, then drives
    step("R7", 0,1,0,0, 1,1,2'b11, 0, 0);
    step("R7", 0,0,0,1, 1,1,2'b11, 0, 0);
    step("R7", 0,0,0,1, 1,1,2'b11, 0, 0);
    // R9: output enable high -> no drive
    step("R9", 0,0,0,0, 1,1,2'b11, 1, 0);
    // R4: processor strobe with global write low while selected
    step("R4", 0,1,0,0, 0,0,2'b00, 0, 18'h15555);
    step("R4", 0,0,0,0, 1,1,2'b11, 0, 0);
    // R1 / R5 / R6: controller write with global write low, oe low
    step("R1", 0,0,1,0, 0,1,2'b11, 0, 18'h2a5a5);
    // R8 / R10: suspend without write stays released, strobe drops
    step("R8", 0,0,0,0, 1,1,2'b11, 0, 0);
    step("R10", 0,0,0,0, 1,1,2'b11, 0, 0);
    // R8: advance read drives again
    step("R8", 0,0,0,1, 1,1,2'b11, 0, 0);
    step("R8", 0,0,0,0, 1,1,2'b11, 0, 0);
    // R2: lane A only, lane B only on advance cycles
    step("R2", 0,0,0,1, 1,0,2'b10, 0, 18'h1fe01);
    step("R2", 0,0,0,1, 1,0,2'b01, 0, 18'h0c1ff);
    step("R2", 0,0,0,0, 1,0,2'b00, 1, 18'h3c3c3);
    // R3: read encodings
    step("R3", 0,0,0,1, 1,1,2'b00, 0, 18'h11111);
    step("R3", 0,0,0,1, 1,0,2'b11, 0, 18'h22222);
    step("R3", 0,0,0,0, 1,1,2'b00, 0, 18'h33333);
    // R6: write on a driving read cycle releases bus at once
    step("R6", 0,0,0,1, 1,0,2'b10, 0, 18'h00abc);
    // R9: deselect, then controller read after deselect is masked
    step("R9", 1,0,0,0, 1,1,2'b11, 0, 0);
    step("R9", 0,0,0,0, 1,1,2'b11, 0, 0);
    step("R7", 0,0,1,0, 1,1,2'b11, 0, 0);
    step("R7", 0,0,0,0, 1,1,2'b11, 0, 0);
    step("R7", 0,0,0,0, 1,1,2'b11, 0, 0);
    // R12: priority among indicators
    step("R12", 1,1,1,1, 0,0,2'b00, 0, 18'h3ffff);
    step("R12", 0,1,1,1, 0,0,2'b00, 0, 18'h3ffff);
    step("R12", 0,0,1,1, 0,0,2'b00, 0, 18'h12345);
    step("R12", 0,0,0,0, 1,1,2'b11, 0, 0);
    // R11: deselect then suspend write ignored
    step("R11", 1,0,0,0, 1,1,2'b11, 0, 0);
    step("R11", 0,0,0,0, 0,0,2'b00, 0, 18'h2ffff);
    step("R11", 0,0,0,1, 0,0,2'b00, 0, 18'h2ffff);
    step("R11", 0,0,0,0, 1,1,2'b11, 0, 0);

    // mixed random stretch
    for (int n = 0; n < 3000; n++) begin
      int r;
      bit d, p, c, a;
      r = $urandom_range(0, 99);
      d = (r < 6);
      p = (r >= 6 && r < 16);
      c = (r >= 16 && r < 28);
      a = (r >= 28 && r < 60);
      step("R2", d, p, c, a, ($urandom_range(0, 5) == 0), $urandom_range(0, 1),
           2'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0),
           18'($urandom()));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule